// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Generator

This block joins two eight-line interrupt resolvers, a primary and a secondary, into a two-level structure. The secondary's "has a winner" indication feeds line 2 of the primary. Each resolver latches requests from its lines, edge-sensed or level-sensed line by line. It picks a winner under a rotating priority and holds in-service bits. A winner only counts when it outranks everything already in service.

When the processor pulses the acknowledge input, the block runs the acknowledge sequence. It marks the winner in service, drops the request if the line is edge-sensed, and applies automatic end-of-interrupt if enabled. When the primary winner is the cascade line, the secondary is acknowledged as well. One cycle later the block presents an 8-bit vector with a one-cycle valid strobe. Each vector is a 5-bit base followed by a 3-bit line number. When a request has disappeared by acknowledge time, line 7 of the relevant resolver is returned.

Bases, masks, trigger modes and auto-EOI options arrive as plain inputs. A non-specific end-of-interrupt pulse per resolver lets software-side logic retire in-service lines.

Top module: `irq_cascade_ack`

## Requirements
- R1: Within a resolver, line L outranks line M when (L - rot) mod 8 is smaller than (M - rot) mod 8. Here rot is the resolver's rotation base, which is 0 after reset.
- R2: A resolver has a winner only when its highest-ranked unmasked pending request outranks its highest-ranked in-service line. A mask bit of 1 blocks a line. `intr` is 1 exactly when the primary has a winner, computed from registered state, so it reflects an acknowledge or input change from the cycle after.
- R3: A line whose trigger-mode bit is 0 becomes pending when its input is 1 in a cycle after a cycle in which it was 0, and stays pending until acknowledged. A line whose trigger-mode bit is 1 is pending exactly while its input was 1 in the previous cycle, and an acknowledge does not clear it.
- R4: Primary line 2 becomes pending in every cycle in which the secondary has a winner. It is cleared when the primary acknowledges line 2.
- R5: `vec_valid` is 1 for exactly the cycle after each cycle in which `inta` is 1. When the primary winner is line L ≠ 2, `vec` = {`mst_vbase`, L}, where the base occupies `vec[7:3]` and the line occupies `vec[2:0]`. That line becomes in service and, if edge-sensed, no longer pending.
- R6: When the primary winner is line 2 and the secondary has winner S, both resolvers are acknowledged and `vec` = {`slv_vbase`, S}.
- R7: When the primary winner is line 2 but the secondary has no winner, `vec` = {`slv_vbase`, 7}. Only the primary is acknowledged.
- R8: When `inta` arrives while the primary has no winner, `vec` = {`mst_vbase`, 7} and no resolver state changes.
- R9: With auto-EOI set, an acknowledged line does not become in service. With rotate-on-auto-EOI also set, the rotation base becomes (line + 1) mod 8.
- R10: A cycle with a resolver's EOI input at 1 clears that resolver's highest-ranked in-service bit.
- R11: During reset `intr`, `vec_valid` and `vec` are 0, and all pending, in-service and rotation state is cleared.
- R12: `vec` changes only in the cycle after an acknowledge, and its upper five bits always equal one of the two bases sampled at the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req | input | 7 | Primary request inputs for lines 0,1,3..7 (bit 0 = line 0, bit 1 = line 1, bit k = line k+1 for k ≥ 2) |
| mst_level | input | 7 | Primary trigger mode per line, same packing; 1 = level |
| mst_mask | input | 8 | Primary mask, bit n masks line n |
| mst_vbase | input | 5 | Primary vector base (vector bits 7:3) |
| mst_aeoi | input | 1 | Primary automatic EOI |
| mst_rot_aeoi | input | 1 | Primary rotate on automatic EOI |
| mst_eoi | input | 1 | Primary non-specific EOI pulse |
| slv_req | input | 8 | Secondary request inputs, bit n = line n |
| slv_level | input | 8 | Secondary trigger mode; 1 = level |
| slv_mask | input | 8 | Secondary mask |
| slv_vbase | input | 5 | Secondary vector base |
| slv_aeoi | input | 1 | Secondary automatic EOI |
| slv_rot_aeoi | input | 1 | Secondary rotate on automatic EOI |
| slv_eoi | input | 1 | Secondary non-specific EOI pulse |
| inta | input | 1 | Processor acknowledge pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector strobe, one cycle after `inta` |
| vec | output | 8 | Acknowledged vector |

## Verification
The bench builds the block with its defaults: cascade on primary line 2 and 5-bit bases. These put the cascade pulse rule, both spurious paths and rotation wrap-around from line 7 to line 0 within a few cycles of stimulus. Directed sequences cover nested service with EOI, level-sensed lines that survive acknowledge, requests that vanish before acknowledge, and masking. A long pseudo-random stretch then mixes acknowledges, EOIs, mode changes and mask changes against the reference model on every clock.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned LINE_W = $clog2(LINES);
  localparam int unsigned RANK_W = LINE_W + 1;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_cascade_pkg::*;
(
  input  logic [LINES-1:0] bits,
  input  line_t            base,
  output logic             found,
  output line_t            line,
  output rank_t            rank
);
  // Scan from lowest to highest priority so the last hit is the best one.
  always_comb begin
    found = 1'b0;
    line  = '0;
    rank  = rank_t'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      line_t idx;
      idx = base + line_t'(k);
      if (bits[idx]) begin
        found = 1'b1;
        line  = idx;
        rank  = rank_t'(k);
      end
    end
  end
endmodule

// File: rtl/irq_line_resolver.sv
module irq_line_resolver
  import irq_cascade_pkg::*;
#(
  parameter logic [LINES-1:0] PULSE_LINES = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_in,
  input  logic [LINES-1:0] level_mode,
  input  logic [LINES-1:0] mask,
  input  logic             ack,
  input  logic             aeoi,
  input  logic             rot_aeoi,
  input  logic             eoi,
  output logic             win_valid,
  output line_t            win_line
);
  localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};
  localparam logic [LINES-1:0] LVL_OK = ~PULSE_LINES;

  logic [LINES-1:0] irr_q, irr_d;
  logic [LINES-1:0] isr_q, isr_d;
  logic [LINES-1:0] last_q;
  line_t            rot_q, rot_d;
  logic             rot_en;

  logic  req_found, svc_found;
  line_t req_line, svc_line;
  rank_t req_rank, svc_rank;

  irq_prio_pick u_req_pick (
    .bits  (irr_q & ~mask),
    .base  (rot_q),
    .found (req_found),
    .line  (req_line),
    .rank  (req_rank)
  );

  irq_prio_pick u_svc_pick (
    .bits  (isr_q),
    .base  (rot_q),
    .found (svc_found),
    .line  (svc_line),
    .rank  (svc_rank)
  );

  assign win_valid = req_found && (req_rank < svc_rank);
  assign win_line  = req_line;

  logic [LINES-1:0] ack_oh, eoi_oh, set_v, lvl_v;

  always_comb begin
    ack_oh = ack ? (ONE << win_line) : '0;
    eoi_oh = (eoi && svc_found) ? (ONE << svc_line) : '0;
    set_v  = (PULSE_LINES & req_in) | (~PULSE_LINES & req_in & ~last_q);
    lvl_v  = level_mode & LVL_OK;
    irr_d  = (lvl_v & req_in) | (~lvl_v & (irr_q | set_v) & ~ack_oh);
    isr_d  = (isr_q & ~eoi_oh) | (aeoi ? '0 : ack_oh);
    rot_en = ack && aeoi && rot_aeoi;
    rot_d  = win_line + line_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
      rot_q  <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      last_q <= req_in;
      if (rot_en) rot_q <= rot_d;
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_cascade_pkg::*;
#(
  parameter int unsigned CASC_LINE = 2,
  parameter int unsigned BASE_W    = 5,
  localparam int unsigned VEC_W    = BASE_W + LINE_W
) (
  input  logic              inta,
  input  logic              m_valid,
  input  line_t             m_line,
  input  logic              s_valid,
  input  line_t             s_line,
  input  logic [BASE_W-1:0] mst_vbase,
  input  logic [BASE_W-1:0] slv_vbase,
  output logic              m_ack,
  output logic              s_ack,
  output logic [VEC_W-1:0]  vec_d
);
  localparam line_t SPURIOUS = line_t'(LINES - 1);

  logic via_casc;

  always_comb begin
    via_casc = m_valid && (m_line == line_t'(CASC_LINE));
    m_ack    = inta && m_valid;
    s_ack    = inta && via_casc && s_valid;
    if (!m_valid)
      vec_d = {mst_vbase, SPURIOUS};
    else if (via_casc)
      vec_d = {slv_vbase, s_valid ? s_line : SPURIOUS};
    else
      vec_d = {mst_vbase, m_line};
  end
endmodule

// File: rtl/irq_cascade_ack.sv
module irq_cascade_ack
  import irq_cascade_pkg::*;
#(
  parameter int unsigned CASC_LINE = 2,
  parameter int unsigned BASE_W    = 5,
  localparam int unsigned VEC_W    = BASE_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-2:0]  mst_req,
  input  logic [LINES-2:0]  mst_level,
  input  logic [LINES-1:0]  mst_mask,
  input  logic [BASE_W-1:0] mst_vbase,
  input  logic              mst_aeoi,
  input  logic              mst_rot_aeoi,
  input  logic              mst_eoi,
  input  logic [LINES-1:0]  slv_req,
  input  logic [LINES-1:0]  slv_level,
  input  logic [LINES-1:0]  slv_mask,
  input  logic [BASE_W-1:0] slv_vbase,
  input  logic              slv_aeoi,
  input  logic              slv_rot_aeoi,
  input  logic              slv_eoi,
  input  logic              inta,
  output logic              intr,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec
);
  localparam logic [LINES-1:0] CASC_OH = {{(LINES-1){1'b0}}, 1'b1} << CASC_LINE;

  logic             s_valid, m_valid, m_ack, s_ack;
  line_t            s_line, m_line;
  logic [LINES-1:0] m_lines, m_lvl;
  logic [VEC_W-1:0] vec_d, vec_q, vec_nx;
  logic             vv_q;

  // Splice the secondary's winner indication into the primary's line set.
  for (genvar j = 0; j < LINES; j++) begin : g_map
    if (j < CASC_LINE) begin : g_lo
      assign m_lines[j] = mst_req[j];
      assign m_lvl[j]   = mst_level[j];
    end else if (j == CASC_LINE) begin : g_casc
      assign m_lines[j] = s_valid;
      assign m_lvl[j]   = 1'b0;
    end else begin : g_hi
      assign m_lines[j] = mst_req[j-1];
      assign m_lvl[j]   = mst_level[j-1];
    end
  end

  irq_line_resolver #(.PULSE_LINES('0)) u_slv (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (slv_req),
    .level_mode (slv_level),
    .mask       (slv_mask),
    .ack        (s_ack),
    .aeoi       (slv_aeoi),
    .rot_aeoi   (slv_rot_aeoi),
    .eoi        (slv_eoi),
    .win_valid  (s_valid),
    .win_line   (s_line)
  );

  irq_line_resolver #(.PULSE_LINES(CASC_OH)) u_mst (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (m_lines),
    .level_mode (m_lvl),
    .mask       (mst_mask),
    .ack        (m_ack),
    .aeoi       (mst_aeoi),
    .rot_aeoi   (mst_rot_aeoi),
    .eoi        (mst_eoi),
    .win_valid  (m_valid),
    .win_line   (m_line)
  );

  irq_ack_seq #(.CASC_LINE(CASC_LINE), .BASE_W(BASE_W)) u_seq (
    .inta      (inta),
    .m_valid   (m_valid),
    .m_line    (m_line),
    .s_valid   (s_valid),
    .s_line    (s_line),
    .mst_vbase (mst_vbase),
    .slv_vbase (slv_vbase),
    .m_ack     (m_ack),
    .s_ack     (s_ack),
    .vec_d     (vec_d)
  );

  always_comb vec_nx = inta ? vec_d : vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      vv_q  <= 1'b0;
    end else begin
      vec_q <= vec_nx;
      vv_q  <= inta;
    end
  end

  assign intr      = m_valid;
  assign vec_valid = vv_q;
  assign vec       = vec_q;
endmodule

// File: rtl/irq_cascade_ack_chk.sv
module irq_cascade_ack_chk
  import irq_cascade_pkg::*;
#(
  parameter int unsigned BASE_W = 5,
  localparam int unsigned VEC_W = BASE_W + LINE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inta,
  input logic              intr,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec,
  input logic [BASE_W-1:0] mst_vbase,
  input logic [BASE_W-1:0] slv_vbase,
  input logic [LINES-1:0]  mst_mask
);
  // R5
  strobe_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_valid);

  // R5
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta));

  // R8
  spurious_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !$past(intr)) |-> (vec == {$past(mst_vbase), {LINE_W{1'b1}}}));

  // R12
  vec_base_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((vec[VEC_W-1:LINE_W] == $past(mst_vbase)) ||
                   (vec[VEC_W-1:LINE_W] == $past(slv_vbase))));

  // R12
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> $stable(vec));

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mst_mask) |-> !intr);
endmodule

bind irq_cascade_ack irq_cascade_ack_chk #(.BASE_W(BASE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inta      (inta),
  .intr      (intr),
  .vec_valid (vec_valid),
  .vec       (vec),
  .mst_vbase (mst_vbase),
  .slv_vbase (slv_vbase),
  .mst_mask  (mst_mask)
);

// File: tb/irq_cascade_ack_tb.sv
module irq_cascade_ack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] mst_req = '0, mst_level = '0;
  logic [7:0] mst_mask = '0;
  logic [4:0] mst_vbase = 5'h04;
  logic       mst_aeoi = 0, mst_rot_aeoi = 0, mst_eoi = 0;
  logic [7:0] slv_req = '0, slv_level = '0, slv_mask = '0;
  logic [4:0] slv_vbase = 5'h0e;
  logic       slv_aeoi = 0, slv_rot_aeoi = 0, slv_eoi = 0;
  logic       inta = 0;
  logic       intr, vec_valid;
  logic [7:0] vec;

  int vectors = 0, fails = 0;
  string tag = "R11";

  bit [7:0] m_irr [2], m_isr [2], m_last [2];
  int       m_rot [2];
  bit       e_vv = 0;
  bit [7:0] e_vec = 0;

  always #4 clk = ~clk;

  irq_cascade_ack u_dut (.*);

  function automatic int best(bit [7:0] b, int rot);
    for (int p = 0; p < 8; p++) if (b[(rot + p) % 8]) return (rot + p) % 8;
    return -1;
  endfunction

  function automatic int winner(int c, bit [7:0] msk);
    int r, s;
    r = best(m_irr[c] & ~msk, m_rot[c]);
    if (r < 0) return -1;
    s = best(m_isr[c], m_rot[c]);
    if (s >= 0 && ((r - m_rot[c] + 8) % 8) >= ((s - m_rot[c] + 8) % 8)) return -1;
    return r;
  endfunction

  task automatic upd(int c, bit [7:0] rq, bit [7:0] lv, bit [7:0] pl, int a,
                     bit ae, bit ro, bit eo);
    int e;
    e = eo ? best(m_isr[c], m_rot[c]) : -1;
    if (e >= 0) m_isr[c][e] = 0;
    for (int l = 0; l < 8; l++) begin
      if (lv[l]) m_irr[c][l] = rq[l];
      else begin
        if (pl[l] ? rq[l] : (rq[l] && !m_last[c][l])) m_irr[c][l] = 1;
        if (l == a) m_irr[c][l] = 0;
      end
    end
    m_last[c] = rq;
    if (a >= 0) begin
      if (!ae) m_isr[c][a] = 1;
      else if (ro) m_rot[c] = (a + 1) % 8;
    end
  endtask

  task automatic check(string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic step();
    int ws, wm, am, as_;
    bit [7:0] mrq, mlv;
    ws = winner(1, slv_mask);
    wm = winner(0, mst_mask);
    am = -1; as_ = -1;
    if (inta) begin
      if (wm < 0) e_vec = {mst_vbase, 3'd7};
      else if (wm == 2) begin
        am = 2;
        if (ws < 0) e_vec = {slv_vbase, 3'd7};
        else begin as_ = ws; e_vec = {slv_vbase, 3'(ws)}; end
      end else begin am = wm; e_vec = {mst_vbase, 3'(wm)}; end
    end
    e_vv = inta;
    for (int l = 0; l < 8; l++) begin
      mrq[l] = (l == 2) ? (ws >= 0) : mst_req[l < 2 ? l : l - 1];
      mlv[l] = (l == 2) ? 1'b0 : mst_level[l < 2 ? l : l - 1];
    end
    upd(0, mrq, mlv, 8'h04, am, mst_aeoi, mst_rot_aeoi, mst_eoi);
    upd(1, slv_req, slv_level, 8'h00, as_, slv_aeoi, slv_rot_aeoi, slv_eoi);
    @(posedge clk); #2;
    check("intr", int'(intr), int'(winner(0, mst_mask) >= 0));
    check("vec_valid", int'(vec_valid), int'(e_vv));
    check("vec", int'(vec), int'(e_vec));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic mline(int l, bit v);
    mst_req[l < 2 ? l : l - 1] = v;
  endtask

  task automatic ack();
    inta = 1; step(); inta = 0; step();
  endtask

  task automatic eoi_both();
    mst_eoi = 1; slv_eoi = 1; step(); mst_eoi = 0; slv_eoi = 0; step();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R5 watchdog got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_irr[c] = 0; m_isr[c] = 0; m_last[c] = 0; m_rot[c] = 0;
    end
    #18;
    // R11: state while reset is held
    check("intr", int'(intr), 0);
    check("vec_valid", int'(vec_valid), 0);
    check("vec", int'(vec), 0);
    #3 rst_n = 1;
    @(posedge clk); #2;
    steps(2);

    // R3 edge capture, R5 direct vector
    tag = "R5";
    mline(5, 1); step(); mline(5, 0); steps(2);
    ack();
    eoi_both();

    // R1 fixed order at rotation 0
    tag = "R1";
    mline(6, 1); mline(1, 1); step(); mline(6, 0); mline(1, 0); steps(2);
    ack(); eoi_both(); ack(); eoi_both();

    // R3 level line survives acknowledge
    tag = "R3";
    mst_level[2] = 1; mline(3, 1); steps(2);
    ack(); eoi_both(); ack(); eoi_both();
    mline(3, 0); steps(2); mst_level[2] = 0; step();

    // R4 and R6 cascaded acknowledge
    tag = "R6";
    slv_req[4] = 1; step(); slv_req[4] = 0; steps(3);
    ack(); eoi_both();

    // R7 secondary request vanishes before acknowledge
    tag = "R7";
    slv_level[1] = 1; slv_req[1] = 1; steps(3);
    slv_req[1] = 0; steps(2);
    ack(); eoi_both(); slv_level[1] = 0;

    // R8 nothing pending; then pending but masked
    tag = "R8";
    ack();
    mline(0, 1); step(); mline(0, 0); mst_mask = 8'h01; steps(2);
    ack(); mst_mask = 8'h00; steps(2); ack(); eoi_both();

    // R2 nested service: lower line held off by in-service higher line
    tag = "R2";
    mline(4, 1); step(); mline(4, 0); steps(2); ack();
    mline(6, 1); step(); mline(6, 0); steps(3);
    mst_mask = 8'hff; steps(2); mst_mask = 8'h00; steps(2);

    // R10 EOI retires highest in-service line, releasing the lower one
    tag = "R10";
    mline(1, 1); step(); mline(1, 0); steps(2); ack();
    mst_eoi = 1; step(); mst_eoi = 0; steps(2);
    ack(); eoi_both(); eoi_both(); eoi_both();

    // R9 auto-EOI with rotation, including wrap from line 7
    tag = "R9";
    mst_aeoi = 1; mst_rot_aeoi = 1;
    mst_level = 7'h7f; mst_req = 7'b1000001; steps(2);
    ack(); ack(); ack(); ack();
    mst_req = 7'b0000001; steps(2); ack();
    mst_req = '0; steps(2);
    mst_rot_aeoi = 0; mline(5, 1); steps(2); ack(); ack();
    mst_req = '0; mst_level = '0; mst_aeoi = 0; steps(2);

    // R12 and everything mixed
    tag = "R12";
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) mst_req = mst_req ^ 7'(1 << (r[7:5] % 7));
      if (r[3:0] == 1) slv_req = slv_req ^ 8'(1 << r[7:5]);
      if (r[9:4] == 2) mst_level = 7'($urandom);
      if (r[9:4] == 3) slv_level = 8'($urandom);
      if (r[10:4] == 4) mst_mask = 8'($urandom) & 8'h5a;
      if (r[10:4] == 5) slv_mask = 8'($urandom) & 8'ha5;
      if (r[11:4] == 6) begin mst_aeoi = r[12]; mst_rot_aeoi = r[13]; end
      if (r[11:4] == 7) begin slv_aeoi = r[12]; slv_rot_aeoi = r[13]; end
      if (r[11:4] == 8) begin mst_vbase = 5'(r[31:27]); slv_vbase = 5'(r[26:22]); end
      inta    = (r[17:15] == 0);
      mst_eoi = (r[20:18] == 0);
      slv_eoi = (r[21:19] == 1);
      step();
    end
    inta = 0; mst_eoi = 0; slv_eoi = 0; steps(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule